// File: doc/BRIEF.md
# Parallel Remote Setpoint Port Controller

This block sits between the parallel remote-control connector of a regulated current supply and its regulation loop. A single strap input sets which way the setpoint lines point. When the strap is pulled low, the unit is a slave: the port lines are inputs, and their value is captured into a register. That captured value replaces the local setpoint at the regulation output, but only when remote operation is also selected. When the strap is left high (open with a pull-up), the unit is a master: it drives its own local setpoint onto the port, so that other units wired to the same lines can track it.

Four asynchronous, active-high command lines (switch on, switch off, clear faults, flip polarity) are synchronised and edge-detected. The resulting single-cycle events drive a small supply-state register. Interlock inputs trip the output and are latched until a clear command arrives. The output state, the polarity flag and the latched faults are always driven out, whatever the strap setting.

Top module: `remote_sp_port`

## Requirements
- R1: With `mode_strap` = 1 (master), `sp_bus_oe` is 1, `sp_bus_out` equals `local_sp`, and `reg_sp` equals `local_sp`.
- R2: With `mode_strap` = 0 (slave), `sp_bus_oe` is 0 and `sp_bus_out` is all zeros.
- R3: In slave mode with `remote_sel` = 1, a value on `sp_bus_in` appears on `reg_sp` after one rising clock edge, provided no command event is present.
- R4: In slave mode with `remote_sel` = 0, `reg_sp` equals `local_sp`, whatever is on `sp_bus_in`.
- R5: In a cycle where an on, off or clear event is present, `sp_bus_in` is not captured, and `reg_sp` keeps its previous captured value.
- R6: Each command input passes through a 2-flop synchroniser and a rising-edge detector. Its effect is visible after the third rising clock edge following the input's rise. A command held high for many cycles acts exactly once.
- R7: If on and off events arrive in the same cycle, the output ends up off (`out_on` = 0).
- R8: An on event is ignored while any bit of `fault_latched` is set.
- R9: Any set bit of `fault_in` clears `out_on` after the next rising edge and sets the matching bit of `fault_latched`. That bit stays set after the input returns low. A clear (reset) event reloads `fault_latched` with the current `fault_in`, so only faults still active stay set.
- R10: A polarity event toggles `pol_neg` only while `out_on` = 0. While the output is on, a polarity event has no effect.
- R11: After synchronous reset, `out_on`, `pol_neg` and `fault_latched` are 0, and the captured setpoint is 0.
- R12: `out_on`, `pol_neg` and `fault_latched` are driven in both strap settings, and changing the strap does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_strap | input | 1 | 1 = master (drive setpoint out), 0 = slave (setpoint in) |
| remote_sel | input | 1 | Remote operation selected |
| cmd_on | input | 1 | Asynchronous switch-on command, active high |
| cmd_off | input | 1 | Asynchronous switch-off command, active high |
| cmd_reset | input | 1 | Asynchronous fault-clear command, active high |
| cmd_invert | input | 1 | Asynchronous polarity-flip command, active high |
| fault_in | input | N_FAULT | Interlock inputs, synchronous, active high |
| local_sp | input | SP_W | Locally generated setpoint |
| sp_bus_in | input | SP_W | Setpoint lines as seen from the port |
| sp_bus_out | output | SP_W | Setpoint driven onto the port in master mode |
| sp_bus_oe | output | 1 | Output enable for the setpoint lines |
| reg_sp | output | SP_W | Setpoint handed to the regulation loop |
| out_on | output | 1 | Supply output enabled |
| pol_neg | output | 1 | Polarity flag (1 = inverted) |
| fault_latched | output | N_FAULT | Latched interlock bits |

## Verification
The bench builds the block with SP_W = 8 and N_FAULT = 3, while keeping the 2-stage synchroniser. With these values every one of the 256 setpoint codes can be swept through the master path, the slave-remote path and the slave-local path. Every one of the 8 interlock patterns can be run through trip, stickiness, on-blocking and clear. The small widths also make a complete sweep affordable: the same exhaustive checks run in every strap and remote combination, next to targeted runs of command timing, held commands, simultaneous on/off, and capture suppression during command events.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int CMD_N = 4;

    // bit 0 = on, bit 1 = off, bit 2 = clear faults, bit 3 = flip polarity
    typedef struct packed {
        logic flip;
        logic clr;
        logic off;
        logic on;
    } cmd_t;

    typedef struct packed {
        logic out_on;
        logic pol_neg;
    } drive_t;

    function automatic drive_t next_drive(drive_t cur, cmd_t c, logic trip, logic blocked);
        drive_t n;
        n = cur;
        if (c.flip && !cur.out_on)
            n.pol_neg = ~cur.pol_neg;
        if (trip || c.off)
            n.out_on = 1'b0;
        else if (c.on && !blocked)
            n.out_on = 1'b1;
        return n;
    endfunction

    function automatic logic capture_allowed(cmd_t c);
        return !(c.on || c.off || c.clr);
    endfunction

endpackage

// File: rtl/rsp_cmd_sync.sv
module rsp_cmd_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    localparam int DEPTH = STAGES + 1;

    logic [N-1:0] pipe [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= din;
    end

    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        (|rise) |=> ((rise & $past(rise)) == '0));

endmodule

// File: rtl/rsp_supply_state.sv
module rsp_supply_state
    import rsp_pkg::*;
#(
    parameter int N_FAULT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  cmd_t               cmd,
    input  logic [N_FAULT-1:0] fault_in,
    output logic               out_on,
    output logic               pol_neg,
    output logic [N_FAULT-1:0] fault_latched
);
    drive_t drv_q, drv_d;
    logic   trip, blocked;

    assign trip    = |fault_in;
    assign blocked = |fault_latched;
    assign drv_d   = next_drive(drv_q, cmd, trip, blocked);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q         <= '0;
            fault_latched <= '0;
        end else begin
            drv_q <= drv_d;
            if (cmd.clr) fault_latched <= fault_in;
            else         fault_latched <= fault_latched | fault_in;
        end
    end

    assign out_on  = drv_q.out_on;
    assign pol_neg = drv_q.pol_neg;

    assert_off_wins_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.off |=> !out_on);

    assert_on_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd.on && (|fault_latched) && !out_on) |=> !out_on);

    assert_trip_R9: assert property (@(posedge clk) disable iff (rst)
        (|fault_in) |=> !out_on);

    assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !cmd.clr |=> ((fault_latched & $past(fault_latched)) == $past(fault_latched)));

    assert_pol_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        out_on |=> $stable(pol_neg));

endmodule

// File: rtl/rsp_sp_path.sv
module rsp_sp_path #(
    parameter int SP_W = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_strap,
    input  logic            remote_sel,
    input  logic            hold,
    input  logic [SP_W-1:0] sp_bus_in,
    input  logic [SP_W-1:0] local_sp,
    output logic [SP_W-1:0] sp_bus_out,
    output logic            sp_bus_oe,
    output logic [SP_W-1:0] reg_sp
);
    logic [SP_W-1:0] sp_cap;
    logic            slave;

    assign slave = !mode_strap;

    always_ff @(posedge clk) begin
        if (rst)
            sp_cap <= '0;
        else if (slave && !hold)
            sp_cap <= sp_bus_in;
    end

    assign sp_bus_oe  = mode_strap;
    assign sp_bus_out = mode_strap ? local_sp : '0;
    assign reg_sp     = (slave && remote_sel) ? sp_cap : local_sp;

    assert_hold_no_capture_R5: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(sp_cap));

    assert_remote_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (slave && remote_sel && !hold && $stable(mode_strap) && $stable(remote_sel))
            |=> (!slave || !remote_sel || reg_sp == $past(sp_bus_in)));

endmodule

// File: rtl/remote_sp_port.sv
module remote_sp_port
    import rsp_pkg::*;
#(
    parameter int SP_W        = 20,
    parameter int N_FAULT     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_strap,
    input  logic               remote_sel,
    input  logic               cmd_on,
    input  logic               cmd_off,
    input  logic               cmd_reset,
    input  logic               cmd_invert,
    input  logic [N_FAULT-1:0] fault_in,
    input  logic [SP_W-1:0]    local_sp,
    input  logic [SP_W-1:0]    sp_bus_in,
    output logic [SP_W-1:0]    sp_bus_out,
    output logic               sp_bus_oe,
    output logic [SP_W-1:0]    reg_sp,
    output logic               out_on,
    output logic               pol_neg,
    output logic [N_FAULT-1:0] fault_latched
);
    logic [CMD_N-1:0] raw_cmd, cmd_rise;
    cmd_t             cmd;
    logic             hold;

    assign raw_cmd = {cmd_invert, cmd_reset, cmd_off, cmd_on};

    rsp_cmd_sync #(.N(CMD_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_cmd),
        .rise (cmd_rise)
    );

    assign cmd  = cmd_t'(cmd_rise);
    assign hold = !capture_allowed(cmd);

    rsp_supply_state #(.N_FAULT(N_FAULT)) u_state (
        .clk           (clk),
        .rst           (rst),
        .cmd           (cmd),
        .fault_in      (fault_in),
        .out_on        (out_on),
        .pol_neg       (pol_neg),
        .fault_latched (fault_latched)
    );

    rsp_sp_path #(.SP_W(SP_W)) u_sp (
        .clk        (clk),
        .rst        (rst),
        .mode_strap (mode_strap),
        .remote_sel (remote_sel),
        .hold       (hold),
        .sp_bus_in  (sp_bus_in),
        .local_sp   (local_sp),
        .sp_bus_out (sp_bus_out),
        .sp_bus_oe  (sp_bus_oe),
        .reg_sp     (reg_sp)
    );

    assert_status_strap_R12: assert property (@(posedge clk) disable iff (rst)
        ($changed(mode_strap) && !(|cmd_rise) && !(|fault_in))
            |-> ($stable(out_on) && $stable(pol_neg)));

endmodule

// File: tb/remote_sp_port_tb.sv
`timescale 1ns/1ps
module remote_sp_port_tb;

    localparam int SP_W = 8;
    localparam int NF   = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_strap, remote_sel;
    logic [3:0]    cmd_drv;
    logic [NF-1:0] fault_in;
    logic [SP_W-1:0] local_sp, sp_bus_in;
    logic [SP_W-1:0] sp_bus_out, reg_sp;
    logic          sp_bus_oe, out_on, pol_neg;
    logic [NF-1:0] fault_latched;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    remote_sp_port #(.SP_W(SP_W), .N_FAULT(NF), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .mode_strap(mode_strap), .remote_sel(remote_sel),
        .cmd_on(cmd_drv[0]), .cmd_off(cmd_drv[1]), .cmd_reset(cmd_drv[2]), .cmd_invert(cmd_drv[3]),
        .fault_in(fault_in), .local_sp(local_sp), .sp_bus_in(sp_bus_in),
        .sp_bus_out(sp_bus_out), .sp_bus_oe(sp_bus_oe), .reg_sp(reg_sp),
        .out_on(out_on), .pol_neg(pol_neg), .fault_latched(fault_latched)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // raise the given command lines for one cycle, then wait until the effect is visible
    task automatic pulse(input logic [3:0] mask);
        cmd_drv = mask;
        @(negedge clk);
        cmd_drv = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual hung expected finish");
        miscompares++;
        finish_run();
    end

    initial begin
        logic exp_pol;
        rst = 1; mode_strap = 0; remote_sel = 1; cmd_drv = '0;
        fault_in = '0; local_sp = 8'hA5; sp_bus_in = 8'h3C;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 out_on", out_on, 0);
        chk("R11 pol_neg", pol_neg, 0);
        chk("R11 fault_latched", fault_latched, 0);
        chk("R11 captured setpoint", reg_sp, 0);
        rst = 0;

        // R3 slave + remote: exhaustive setpoint sweep
        mode_strap = 0; remote_sel = 1;
        for (int v = 0; v < 256; v++) begin
            sp_bus_in = v[SP_W-1:0];
            local_sp  = ~v[SP_W-1:0];
            @(negedge clk);
            chk("R3 reg_sp follows bus", reg_sp, v);
        end

        // R2 / R4 slave, local: reg_sp from local, bus not driven
        remote_sel = 0;
        for (int v = 0; v < 256; v++) begin
            local_sp  = v[SP_W-1:0];
            sp_bus_in = v[SP_W-1:0] ^ 8'h5A;
            @(negedge clk);
            chk("R4 reg_sp local", reg_sp, v);
            chk("R2 oe low", sp_bus_oe, 0);
            chk("R2 bus_out zero", sp_bus_out, 0);
        end

        // R1 master: local driven onto bus and to regulation, both remote settings
        mode_strap = 1;
        for (int r = 0; r < 2; r++) begin
            remote_sel = r[0];
            for (int v = 0; v < 256; v++) begin
                local_sp  = v[SP_W-1:0];
                sp_bus_in = ~v[SP_W-1:0];
                @(negedge clk);
                chk("R1 oe high", sp_bus_oe, 1);
                chk("R1 bus_out", sp_bus_out, v);
                chk("R1 reg_sp", reg_sp, v);
            end
        end

        // R5 capture suppressed during an on/off/clear event
        mode_strap = 0; remote_sel = 1;
        for (int k = 0; k < 3; k++) begin
            sp_bus_in = 8'h11 * (k + 1);
            @(negedge clk);
            cmd_drv = 4'b0001 << k;
            @(negedge clk);
            cmd_drv = '0;
            @(negedge clk);
            sp_bus_in = 8'hE0 + k[7:0];
            @(negedge clk);
            chk("R5 no capture in event cycle", reg_sp, 8'h11 * (k + 1));
            @(negedge clk);
            chk("R5 capture resumes", reg_sp, 8'hE0 + k);
        end
        pulse(4'b0010);

        // R6 timing: on visible only after third edge
        cmd_drv = 4'b0001;
        @(negedge clk);
        cmd_drv = '0;
        @(negedge clk);
        chk("R6 not yet on", out_on, 0);
        @(negedge clk);
        chk("R6 on after third edge", out_on, 1);
        pulse(4'b0010);
        chk("R6 off", out_on, 0);

        // R6 held command acts once; R10 flip while off
        exp_pol = pol_neg;
        cmd_drv = 4'b1000;
        repeat (12) @(negedge clk);
        cmd_drv = '0;
        repeat (3) @(negedge clk);
        exp_pol = ~exp_pol;
        chk("R6 held flip acts once", pol_neg, exp_pol);
        pulse(4'b1000);
        exp_pol = ~exp_pol;
        chk("R10 flip while off", pol_neg, exp_pol);

        // R10 flip while on ignored
        pulse(4'b0001);
        chk("R10 turned on", out_on, 1);
        pulse(4'b1000);
        chk("R10 flip ignored while on", pol_neg, exp_pol);

        // R7 simultaneous on/off from on and from off
        pulse(4'b0011);
        chk("R7 off wins (was on)", out_on, 0);
        pulse(4'b0011);
        chk("R7 off wins (was off)", out_on, 0);

        // R8 / R9 exhaustive fault patterns
        for (int p = 0; p < 8; p++) begin
            pulse(4'b0100);
            pulse(4'b0001);
            chk("R9 on before fault", out_on, 1);
            fault_in = p[NF-1:0];
            @(negedge clk);
            chk("R9 trip", out_on, (p == 0) ? 1 : 0);
            chk("R9 latch set", fault_latched, p);
            fault_in = '0;
            @(negedge clk);
            chk("R9 latch sticky", fault_latched, p);
            pulse(4'b0001);
            chk("R8 on blocked by fault", out_on, (p == 0) ? 1 : 0);
            pulse(4'b0100);
            chk("R9 cleared", fault_latched, 0);
            pulse(4'b0001);
            chk("R8 on after clear", out_on, 1);
            pulse(4'b0010);
        end

        // R9 clear with a fault still active keeps it
        fault_in = 3'b101;
        @(negedge clk);
        pulse(4'b0100);
        chk("R9 active fault survives clear", fault_latched, 3'b101);
        fault_in = '0;
        @(negedge clk);
        pulse(4'b0100);
        chk("R9 clear after release", fault_latched, 0);

        // R12 status unaffected by strap changes
        pulse(4'b0001);
        fault_in = 3'b010;
        @(negedge clk);
        fault_in = '0;
        for (int m = 0; m < 4; m++) begin
            mode_strap = m[0];
            @(negedge clk);
            chk("R12 out_on", out_on, 0);
            chk("R12 pol_neg", pol_neg, exp_pol);
            chk("R12 fault_latched", fault_latched, 3'b010);
        end

        finish_run();
    end

endmodule